// File: doc/BRIEF.md
# Serial Control Port with Command-Driven Soft Reset

This block is the configuration front end of an audio codec. A host drives three pins: a shift clock, a serial data line and an active-low frame select. Each frame carries one 16-bit command word. The upper seven bits are a register address and the lower nine bits are the value. When the frame select returns high, the value is stored in a bank of nine-bit configuration registers. The whole bank is exported as one flat vector to the rest of the codec.

One address acts as a command rather than a storage location. Writing an all-zero value there raises a soft-reset pulse on the frame-select rising edge, and every configuration register returns to zero. The pulse drops on the next rising edge of the shift clock. A second function uses one bit of the bank to choose the core rate. The block produces a core clock enable in the master-clock domain that is high on every cycle for a full-rate core, or on every other cycle so that a 512fs master clock can run a 256fs core.

The three pins are asynchronous to the master clock. They are resynchronised and then edge-detected, so the whole block runs on the master clock alone.

Top module: `ctl_port`

## Requirements
- R1: After `rst_n` is released, every nine-bit field of `cfg_o` is zero, `soft_rst_o` is 0 and `core_en_o` is 1.
- R2: While `csb` is low, each rising `sclk` edge shifts one `sdin` bit in, MSB first. When `csb` rises after exactly 16 bits, bits 15..9 are taken as the address and bits 8..0 as the value. If the address is below `NUM_REGS` (default 10), the value appears in `cfg_o[addr*9 +: 9]`.
- R3: A frame that ends with any bit count other than 16 (for example 15 or 17) leaves `cfg_o` and `soft_rst_o` unchanged.
- R4: A 16-bit write to an address from `NUM_REGS` to 14, or from 16 to 127, changes nothing. A write of a nonzero value to address 15 also changes nothing and raises no soft reset.
- R5: A 16-bit write of value 0 to address 15 sets `soft_rst_o` to 1 within four master-clock cycles of the `csb` rising edge. While it is 1, every field of `cfg_o` reads zero.
- R6: `soft_rst_o` stays 1 until the next rising `sclk` edge, even across a `csb` low/high pulse that carries no bits. It then drops to 0.
- R7: In the frame whose first rising `sclk` edge ends the soft reset, that first bit is still shifted in. The frame is stored intact.
- R8: Bit 6 of register 8 is the core-rate select. When it is 0, `core_en_o` is 1 on every cycle. When it is 1, `core_en_o` alternates, so it is high on exactly half of any even-length run of cycles. The other bits of register 8 do not affect `core_en_o`.
- R9: A falling `csb` edge restarts the bit count. A full 16-bit frame that follows an aborted short frame is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every flop in the block runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial shift clock from the host, asynchronous |
| csb | input | 1 | Active-low frame select from the host, asynchronous |
| sdin | input | 1 | Serial command data, MSB first |
| cfg_o | output | NUM_REGS*9 | Configuration bank; register n is at bits n*9 +: 9 |
| soft_rst_o | output | 1 | Soft-reset pulse raised by the reset command |
| core_en_o | output | 1 | Core clock enable: full rate or every other master-clock cycle |

## Verification
The shift counter and the shift register are not visible at the ports. A wrong bit count shows up only at the next `csb` rising edge, a few master-clock cycles later. It appears as a field of `cfg_o` that should have changed and did not, or that changed when it should not have. A soft-reset flag set or cleared at the wrong time shows as a zero bank or a missing write at the end of the same frame. A toggle flop stuck in the core-rate path shows up within two cycles as a wrong `core_en_o` pattern. The bench therefore compares the whole bank after every frame and counts enable pulses over a fixed window.

// File: rtl/ctl_port_pkg.sv
// Shared widths and the command-word layout for the serial control port.
// Assumes one command per frame: address in the high bits, value in the low bits.
package ctl_port_pkg;
    localparam int AW    = 7;          // address field width
    localparam int DW    = 9;          // register value width
    localparam int FRAME = AW + DW;    // bits per valid frame

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;
endpackage

// File: rtl/ctl_sync.sv
// Multi-stage resynchroniser for a group of asynchronous single-bit inputs.
// Assumes each bit is independent; the group is not treated as a coherent bus.
module ctl_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_rx.sv
// Frame receiver: detects edges of the resynchronised serial pins, shifts bits
// in on rising shift-clock edges while the frame select is low, and flags a
// complete command when the select rises after exactly FRAME bits.
// Assumes the serial pins are already synchronised to clk and that the pin
// rate is well below clk, so that every pin edge is seen.
module ctl_rx
    import ctl_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic csb_s,
    input  logic sdin_s,
    output logic sclk_rise,
    output logic cmd_vld,
    output cmd_t cmd
);
    localparam int CNT_MAX = FRAME + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic             sclk_q, csb_q;
    logic             csb_fall, csb_rise, take_bit;
    logic [FRAME-1:0] shreg;
    logic [CW-1:0]    cnt;

    // Previous pin levels, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csb_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csb_q  <= csb_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign csb_fall  = csb_q & ~csb_s;
    assign csb_rise  = ~csb_q & csb_s;
    assign take_bit  = sclk_rise & ~csb_s;

    // Shift register; the soft reset deliberately leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (take_bit) shreg <= {shreg[FRAME-2:0], sdin_s};
    end

    // Bit counter: cleared at frame start, saturates one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt <= '0;
        else if (csb_fall)                        cnt <= '0;
        else if (take_bit && cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
    end

    assign cmd_vld = csb_rise && (cnt == CW'(FRAME));
    assign cmd     = cmd_t'(shreg);
endmodule

// File: rtl/ctl_regbank.sv
// Configuration register bank and soft-reset control. A valid command that
// hits an implemented address stores its value. The all-zero command to the
// reset address clears the bank and raises soft_rst until the next rising
// shift-clock edge.
// Assumes NUM_REGS does not reach RST_ADDR.
module ctl_regbank
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int RST_ADDR = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_vld,
    input  cmd_t                   cmd,
    input  logic                   sclk_rise,
    output logic [NUM_REGS*DW-1:0] cfg,
    output logic                   soft_rst
);
    logic srst_cmd;
    logic clr;

    assign srst_cmd = cmd_vld && (cmd.addr == AW'(RST_ADDR)) && (cmd.data == '0);
    assign clr      = srst_cmd || soft_rst;

    // Soft-reset flag: set by the reset command, cleared by the next shift edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         soft_rst <= 1'b0;
        else if (srst_cmd)  soft_rst <= 1'b1;
        else if (sclk_rise) soft_rst <= 1'b0;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DW-1:0] r;

        // One configuration register: cleared by either reset, loaded on an address hit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                          r <= '0;
            else if (cmd_vld && cmd.addr == AW'(g))     r <= cmd.data;
        end

        assign cfg[g*DW +: DW] = r;
    end
endmodule

// File: rtl/ctl_clken.sv
// Core clock enable. Produces a continuous enable for a full-rate core, or a
// toggling enable (every other master-clock cycle) when the divide select is 1.
// Assumes div_sel is already in the clk domain.
module ctl_clken (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic div_sel,
    output logic core_en
);
    logic tgl;

    // Toggle flop: runs only while the divide select is set.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) tgl <= 1'b0;
        else if (div_sel)       tgl <= ~tgl;
        else                    tgl <= 1'b0;
    end

    assign core_en = !div_sel || tgl;
endmodule

// File: rtl/ctl_port.sv
// Top of the serial control port: pin resynchronisers, frame receiver,
// register bank with soft reset, and core clock enable.
// Assumes the host's shift clock runs well below clk / 4.
module ctl_port
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int RST_ADDR    = 15,
    parameter int DIV_ADDR    = 8,
    parameter int DIV_BIT     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   csb,
    input  logic                   sdin,
    output logic [NUM_REGS*DW-1:0] cfg_o,
    output logic                   soft_rst_o,
    output logic                   core_en_o
);
    localparam int DIV_POS = DIV_ADDR * DW + DIV_BIT;

    logic [2:0] pins_s;
    logic       sclk_rise;
    logic       cmd_vld;
    cmd_t       cmd;
    logic       div_sel;

    ctl_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, csb, sdin}),
        .q    (pins_s)
    );

    ctl_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[2]),
        .csb_s    (pins_s[1]),
        .sdin_s   (pins_s[0]),
        .sclk_rise(sclk_rise),
        .cmd_vld  (cmd_vld),
        .cmd      (cmd)
    );

    ctl_regbank #(
        .NUM_REGS(NUM_REGS),
        .RST_ADDR(RST_ADDR)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_vld  (cmd_vld),
        .cmd      (cmd),
        .sclk_rise(sclk_rise),
        .cfg      (cfg_o),
        .soft_rst (soft_rst_o)
    );

    assign div_sel = cfg_o[DIV_POS];

    ctl_clken u_clken (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst_o),
        .div_sel (div_sel),
        .core_en (core_en_o)
    );
endmodule

// File: rtl/ctl_port_chk.sv
// Assertion checker for ctl_port, attached with bind below.
// Relates the receiver's command flags to the bank, the soft reset and the enable.
module ctl_port_chk
    import ctl_port_pkg::*;
#(
    parameter int NUM_REGS = 10,
    parameter int RST_ADDR = 15
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sclk_rise,
    input logic                   cmd_vld,
    input cmd_t                   cmd,
    input logic [NUM_REGS*DW-1:0] cfg,
    input logic                   soft_rst,
    input logic                   div_sel,
    input logic                   core_en
);
    AST_SRST_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $past(cmd_vld && cmd.addr == AW'(RST_ADDR) && cmd.data == '0)); // R5

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> cfg == '0); // R5

    AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !sclk_rise |=> soft_rst); // R6

    AST_SRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && sclk_rise |=> !soft_rst); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld && !soft_rst && (int'(cmd.addr) < NUM_REGS)
        |=> cfg[int'($past(cmd.addr))*DW +: DW] == $past(cmd.data)); // R2

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld && !soft_rst |=> $stable(cfg)); // R3

    AST_EN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        div_sel && $past(div_sel) |-> core_en != $past(core_en)); // R8
endmodule

bind ctl_port ctl_port_chk #(
    .NUM_REGS(NUM_REGS),
    .RST_ADDR(RST_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_rise(sclk_rise),
    .cmd_vld  (cmd_vld),
    .cmd      (cmd),
    .cfg      (cfg_o),
    .soft_rst (soft_rst_o),
    .div_sel  (div_sel),
    .core_en  (core_en_o)
);

// File: tb/sim_ctl_port.sv
// Scoreboard bench for ctl_port: the frame driver updates a reference bank and
// queues expected register values; a monitor compares them at falling edges.
module sim_ctl_port;
    localparam int NREG  = 10;
    localparam int DWB   = 9;
    localparam int LIMIT = 100000;

    typedef struct {
        string          req;
        int             idx;
        logic [DWB-1:0] exp;
        int             due;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic csb = 1'b1;
    logic sdin = 1'b0;
    logic [NREG*DWB-1:0] cfg_o;
    logic soft_rst_o;
    logic core_en_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [DWB-1:0] ref_bank [NREG];
    item_t sbq [$];
    item_t it;

    always #2 clk = ~clk;

    ctl_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .csb       (csb),
        .sdin      (sdin),
        .cfg_o     (cfg_o),
        .soft_rst_o(soft_rst_o),
        .core_en_o (core_en_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_bank(string req);
        for (int i = 0; i < NREG; i++) begin
            item_t x;
            x.req = req;
            x.idx = i;
            x.exp = ref_bank[i];
            x.due = cyc + 1;
            sbq.push_back(x);
        end
    endtask

    // Drives one frame of nbits (MSB first) and updates the reference bank.
    task automatic send(int nbits, logic [31:0] word);
        logic [6:0] a;
        logic [8:0] d;
        csb = 1'b0;
        tick(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdin = word[i];
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
        tick(4);
        csb = 1'b1;
        tick(8);
        a = word[15:9];
        d = word[8:0];
        if (nbits == 16) begin
            if (int'(a) < NREG) ref_bank[a] = d;
            else if (a == 7'd15 && d == 9'd0)
                for (int i = 0; i < NREG; i++) ref_bank[i] = '0;
        end
    endtask

    task automatic count_en(int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (core_en_o) hits++;
        end
    endtask

    function automatic logic [31:0] mk(int a, int d);
        return 32'((a << 9) | d);
    endfunction

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected<%0d", cyc, LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Monitor: compare queued expectations once they fall due.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it = sbq.pop_front();
            chk(it.req, 32'(cfg_o[it.idx*DWB +: DWB]), 32'(it.exp));
        end
    end

    initial begin
        int hits;
        for (int i = 0; i < NREG; i++) ref_bank[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk("R1 soft_rst", 32'(soft_rst_o), 32'd0);
        chk("R1 core_en", 32'(core_en_o), 32'd1);
        push_bank("R1");
        tick(2);

        // R2: plain writes
        send(16, mk(3, 9'h1A5));
        send(16, mk(0, 9'h0FF));
        send(16, mk(9, 9'h100));
        push_bank("R2");
        tick(2);

        // R3: wrong bit counts are discarded
        send(15, mk(3, 9'h011) >> 1);
        send(17, {mk(3, 9'h022), 1'b1});
        chk("R3 soft_rst", 32'(soft_rst_o), 32'd0);
        push_bank("R3");
        tick(2);

        // R9: aborted short frame, then a full frame
        send(6, 32'h2A);
        send(16, mk(5, 9'h033));
        push_bank("R9");
        tick(2);

        // R4: unimplemented addresses and nonzero reset value
        send(16, mk(12, 9'h1FF));
        send(16, mk(100, 9'h0AA));
        send(16, mk(15, 9'h001));
        chk("R4 soft_rst", 32'(soft_rst_o), 32'd0);
        push_bank("R4");
        tick(2);

        // R8: other bits of register 8 leave the enable at full rate
        send(16, mk(8, 9'h1BF));
        count_en(40, hits);
        chk("R8 full rate", 32'(hits), 32'd40);
        send(16, mk(8, 9'h040));
        count_en(40, hits);
        chk("R8 half rate", 32'(hits), 32'd20);
        push_bank("R8");
        tick(2);

        // R5: reset command clears the bank
        send(16, mk(15, 9'h000));
        chk("R5 soft_rst", 32'(soft_rst_o), 32'd1);
        push_bank("R5");
        tick(2);

        // R6: an empty select pulse does not end the reset
        csb = 1'b0;
        tick(6);
        csb = 1'b1;
        tick(8);
        chk("R6 hold", 32'(soft_rst_o), 32'd1);

        // R7: the frame that ends the reset is stored intact
        send(16, mk(8, 9'h040));
        chk("R6 release", 32'(soft_rst_o), 32'd0);
        push_bank("R7");
        tick(2);
        count_en(40, hits);
        chk("R7 half rate after reset", 32'(hits), 32'd20);

        tick(4);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule